// File: doc/BRIEF.md
# Primary Interrupt Aggregator

This block is the upper stage of a two-level interrupt controller. Up to eight secondary interrupt modules each present a request toward each of two host masters. The aggregator samples these requests into one status register per output line. It then drives one active-low interrupt pin per line. The host that owns a line reads that line's status byte and learns which secondary modules need service. It then turns to those modules, which keep their own masks and edge logic.

Slot n of each status register belongs to secondary module n and to no other. Slots that no module occupies are fixed at zero by a presence mask parameter. Some modules have only one request output. For a slot marked in the one-line mask, the line-1 request feeds both status registers, and that slot's line-2 input is not used.

A test register lets software force status bits for bring-up. It is written through the same byte-wide register port that reads the two status registers.

Top module: `irq_primary_agg`

## Requirements
- R1: While reset is asserted and on release, both status registers and the test register read 0x00, and both interrupt pins are high.
- R2: Status bit n of a line is 1 in the clock cycle after the request of module n toward that line is sampled high. It returns to 0 one cycle after that request is sampled low, provided the test register has bit n clear.
- R3: Register reads are combinational on the address. Address 1 returns the line-1 status, address 2 the line-2 status, address 3 the test register, and address 0 returns 0x00.
- R4: Writes to address 1 or 2 change neither status register nor the test register.
- R5: A write to address 3 loads the test register at that clock edge, with bits of unoccupied slots forced to 0. One cycle later its bits are OR-ed into both status registers.
- R6: Writing 0x00 to address 3 clears the test register. One cycle later the forced bits leave both status registers, unless a live request still holds them.
- R7: Status bits of slots outside the presence mask read 0 on both lines, whatever the request inputs or the test write.
- R8: For a slot in the one-line mask, line-2 status follows that slot's line-1 request, and its line-2 request input has no effect.
- R9: Each interrupt pin is low exactly while its line's status register is non-zero, and it changes in the same cycle as the status register.
- R10: A request toward one line does not appear in the other line's status, except for one-line slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| req_l1 | input | N_SLOTS | Per-module requests toward line 1 |
| req_l2 | input | N_SLOTS | Per-module requests toward line 2 |
| reg_addr | input | 2 | Register offset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_wdata | input | N_SLOTS | Write data |
| reg_rdata | output | N_SLOTS | Read data for reg_addr |
| int1_n | output | 1 | Line-1 interrupt pin, active low |
| int2_n | output | 1 | Line-2 interrupt pin, active low |

## Verification
On every clock cycle the assertions check four things. The line-1 status read back equals the previous cycle's requests OR-ed with the test register, under the presence mask. One-line slots track the line-1 request on line 2. Unoccupied slots stay zero. Each pin agrees with the status byte seen on the port. The bench's scenarios are needed to show the rest: line independence for mixed request patterns, the write-then-clear timing of the test register, that writes to the status addresses are ignored, and the reset values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_AW  = 2;
  localparam int N_LINES = 2;

  typedef enum logic [REG_AW-1:0] {
    OFF_NONE    = 2'd0,
    OFF_STAT_L1 = 2'd1,
    OFF_STAT_L2 = 2'd2,
    OFF_TSET    = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irq_agg_testset.sv
module irq_agg_testset #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tset_q
);
  logic [W-1:0] tset_d;
  logic         tset_en;

  always_comb begin
    tset_en = wr_hit;
    tset_d  = wdata & PRESENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tset_q <= '0;
    else if (tset_en) tset_q <= tset_d;
  end
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line #(
  parameter int           W        = 8,
  parameter logic [W-1:0] PRESENT  = '1,
  parameter logic [W-1:0] ONE_LINE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_own,
  input  logic [W-1:0] req_primary,
  input  logic [W-1:0] tset,
  output logic [W-1:0] stat_q,
  output logic         irq_n
);
  logic [W-1:0] req_eff;
  logic [W-1:0] stat_d;
  logic         stat_en;

  // one-line slots take the line-1 request; others take their own line
  always_comb begin
    req_eff = (req_own & ~ONE_LINE) | (req_primary & ONE_LINE);
    stat_d  = (req_eff | tset) & PRESENT;
    stat_en = (stat_d != stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign irq_n = ~(|stat_q);
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      stat_l1,
  input  logic [W-1:0]      stat_l2,
  input  logic [W-1:0]      tset,
  output logic [W-1:0]      rdata
);
  always_comb begin
    unique case (reg_off_e'(addr))
      OFF_STAT_L1: rdata = stat_l1;
      OFF_STAT_L2: rdata = stat_l2;
      OFF_TSET:    rdata = tset;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_primary_agg.sv
module irq_primary_agg
  import irq_agg_pkg::*;
#(
  parameter int                 N_SLOTS        = 8,
  parameter logic [N_SLOTS-1:0] SLOT_PRESENT   = 8'h3F,
  parameter logic [N_SLOTS-1:0] ONE_LINE_SLOTS = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req_l1,
  input  logic [N_SLOTS-1:0] req_l2,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr_en,
  input  logic [N_SLOTS-1:0] reg_wdata,
  output logic [N_SLOTS-1:0] reg_rdata,
  output logic               int1_n,
  output logic               int2_n
);
  logic [N_LINES-1:0][N_SLOTS-1:0] req_line;
  logic [N_LINES-1:0][N_SLOTS-1:0] stat_line;
  logic [N_LINES-1:0]              irq_line_n;
  logic [N_SLOTS-1:0]              tset_q;
  logic                            tset_wr;

  assign req_line[0] = req_l1;
  assign req_line[1] = req_l2;
  assign tset_wr     = reg_wr_en && (reg_off_e'(reg_addr) == OFF_TSET);

  irq_agg_testset #(.W(N_SLOTS), .PRESENT(SLOT_PRESENT)) u_tset (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (tset_wr),
    .wdata  (reg_wdata),
    .tset_q (tset_q)
  );

  for (genvar li = 0; li < N_LINES; li++) begin : g_line
    irq_agg_line #(
      .W        (N_SLOTS),
      .PRESENT  (SLOT_PRESENT),
      .ONE_LINE (ONE_LINE_SLOTS)
    ) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_own     (req_line[li]),
      .req_primary (req_line[0]),
      .tset        (tset_q),
      .stat_q      (stat_line[li]),
      .irq_n       (irq_line_n[li])
    );
  end

  irq_agg_rdmux #(.W(N_SLOTS)) u_rdmux (
    .addr    (reg_addr),
    .stat_l1 (stat_line[0]),
    .stat_l2 (stat_line[1]),
    .tset    (tset_q),
    .rdata   (reg_rdata)
  );

  assign int1_n = irq_line_n[0];
  assign int2_n = irq_line_n[1];
endmodule

// File: rtl/irq_primary_agg_chk.sv
module irq_primary_agg_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] PRESENT  = '1,
  parameter logic [W-1:0] ONE_LINE = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] req_l1,
  input logic [1:0]   reg_addr,
  input logic         reg_wr_en,
  input logic [W-1:0] reg_rdata,
  input logic         int1_n,
  input logic         int2_n,
  input logic [W-1:0] tset_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_pins_idle_at_release: assert property (@(posedge clk)
    $rose(rst_n) |-> (int1_n && int2_n));

  a_r2_line1_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_addr == 2'd1) |->
      (reg_rdata == ($past(req_l1 | tset_q) & PRESENT)));

  a_r8_one_line_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_addr == 2'd2) |->
      ((reg_rdata & ONE_LINE) == ($past(req_l1 | tset_q) & ONE_LINE & PRESENT)));

  a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1 || reg_addr == 2'd2) |-> ((reg_rdata & ~PRESENT) == '0));

  a_r4_stat_write_no_tset: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_wr_en && (reg_addr == 2'd1 || reg_addr == 2'd2)) |=> $stable(tset_q));

  a_r9_pin1_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (int1_n == (reg_rdata == '0)));

  a_r9_pin2_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (int2_n == (reg_rdata == '0)));
endmodule

bind irq_primary_agg irq_primary_agg_chk #(
  .W        (N_SLOTS),
  .PRESENT  (SLOT_PRESENT),
  .ONE_LINE (ONE_LINE_SLOTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_l1    (req_l1),
  .reg_addr  (reg_addr),
  .reg_wr_en (reg_wr_en),
  .reg_rdata (reg_rdata),
  .int1_n    (int1_n),
  .int2_n    (int2_n),
  .tset_q    (tset_q)
);

// File: tb/irq_primary_agg_tb.sv
module irq_primary_agg_tb;
  localparam int         W    = 8;
  localparam logic [7:0] PRES = 8'h7F;
  localparam logic [7:0] ONE  = 8'h40;
  localparam int         NV   = 7;
  // {req_l1, req_l2, expected line-1 status, expected line-2 status}
  localparam logic [NV-1:0][31:0] VEC = {
    32'h40_00_40_40,
    32'hA5_5A_25_1A,
    32'h00_FF_00_3F,
    32'hFF_00_7F_40,
    32'h00_22_00_22,
    32'h01_00_01_00,
    32'h00_00_00_00
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] req_l1, req_l2, reg_wdata, reg_rdata;
  logic [1:0]   reg_addr;
  logic         reg_wr_en, int1_n, int2_n;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  irq_primary_agg #(.N_SLOTS(W), .SLOT_PRESENT(PRES), .ONE_LINE_SLOTS(ONE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_l1(req_l1), .req_l2(req_l2),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int1_n(int1_n), .int2_n(int2_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic lines(input string req, input logic [7:0] e1, input logic [7:0] e2);
    logic [7:0] d;
    rd(2'd1, d); check({req, " line1"}, d, e1);
    check("R9 pin1", {7'd0, int1_n}, {7'd0, e1 == 8'h00});
    rd(2'd2, d); check({req, " line2"}, d, e2);
    check("R9 pin2", {7'd0, int2_n}, {7'd0, e2 == 8'h00});
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; req_l1 = '0; req_l2 = '0;
    reg_addr = 2'd0; reg_wr_en = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    lines("R1 reset", 8'h00, 8'h00);
    rd(2'd3, d); check("R1 test reg", d, 8'h00);
    rst_n = 1'b1;

    // vector walk: R2, R7, R8, R9, R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_l1 = VEC[i][31:24]; req_l2 = VEC[i][23:16];
      @(negedge clk);
      lines($sformatf("R2/R10 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
    end
    // R2: deassert clears
    req_l1 = '0; req_l2 = '0;
    @(negedge clk);
    lines("R2 clear", 8'h00, 8'h00);

    // R3: address 0 reads zero
    rd(2'd0, d); check("R3 addr0", d, 8'h00);

    // R4: writes to status addresses ignored
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    @(negedge clk);
    lines("R4 stat write", 8'h00, 8'h00);
    rd(2'd3, d); check("R4 test reg", d, 8'h00);

    // R5: test set, then forced into both lines a cycle later
    wr(2'd3, 8'h0C);
    rd(2'd3, d); check("R5 test readback", d, 8'h0C);
    @(negedge clk);
    lines("R5 forced", 8'h0C, 8'h0C);

    // R7: absent slot bit dropped from test register
    wr(2'd3, 8'h83);
    rd(2'd3, d); check("R7 test mask", d, 8'h03);
    req_l1 = 8'h10;
    @(negedge clk);
    lines("R5 OR with req", 8'h13, 8'h03);

    // R6: clear test register, live request survives
    wr(2'd3, 8'h00);
    @(negedge clk);
    lines("R6 cleared", 8'h10, 8'h00);
    req_l1 = '0;
    @(negedge clk);
    lines("R6 idle", 8'h00, 8'h00);

    // R8: line-2 input of one-line slot ignored
    req_l2 = 8'hC0;
    @(negedge clk);
    lines("R8 l2 ignored", 8'h00, 8'h00);
    req_l2 = '0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule